// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block sits beside a processor core and gives it a timer interrupt and an interrupt-pending / interrupt-mask pair. It holds a 32-bit counter that advances by one on each tick strobe and a 32-bit compare value. When the counter reaches the compare value, a sticky timer-pending bit is set. That bit sits in the cause register together with seven pending bits that software can set.

An interrupt request goes out whenever the global enable in the status register is set and at least one pending bit is set whose mask bit in the status register is also set. The request is a level output.

Software reaches the four registers through a single select / read / write port. An access from a non-kernel privilege level is refused while the coprocessor-usable bit is clear. A refused access raises a coprocessor-unusable signal and zeroes the coprocessor-error field of the cause register.

Top module: `cpt_timer_irq`

## Requirements
- R1: After reset the count, compare, status and cause registers all read zero, and `irq_req` is low.
- R2: Each cycle with `tick` high and no count write adds exactly one to count. The addition wraps from 0xFFFFFFFF to 0.
- R3: The match test uses the count value after the increment. A tick that makes count equal compare sets cause bit 15 on the same clock edge. A tick starting from count equal to compare does not set it.
- R4: Cause bit 15 stays set on further ticks. A software write to cause does not change it.
- R5: A software write to compare clears cause bit 15.
- R6: A count write in the same cycle as a tick loads the written value, with no increment and no match test in that cycle.
- R7: `irq_req` = status bit 0 AND (cause[15:8] AND status[15:8] non-zero). It is combinational from register state and is not tied to ticks.
- R8: When `kernel_mode` is low and status bit 28 is clear, an access (read or write) drives `cop_unusable` high in the same cycle. A write made this way is discarded, and a read made this way returns zero.
- R9: A refused access writes 00 into cause bits 29:28.
- R10: `reg_sel` selects 0 = count, 1 = compare, 2 = status, 3 = cause. In status only bits 31:28, 15:8 and 0 are kept. In cause only bits 29:28 and 14:8 are written by software. All other bits read zero, and `rd_data` is zero when `reg_rd` is low.
- R11: An access is accepted when `kernel_mode` is high or status bit 28 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count advance strobe |
| kernel_mode | input | 1 | High when the requester runs at kernel privilege |
| reg_sel | input | 2 | Register select (0 count, 1 compare, 2 status, 3 cause) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| cop_unusable | output | 1 | Refused access this cycle |
| irq_req | output | 1 | Level interrupt request |

## Verification
The match logic is tried with three approaches to the compare value:
- a tick landing exactly on compare;
- a tick that starts already on compare, which separates a test of the new count from a test of the old one;
- a wrap through zero onto a zero compare.

A count write that coincides with a tick shows which of the two wins and whether a match is tested in that cycle.

The request output is tried with these patterns:
- enable off;
- pending and mask bits that do not overlap;
- overlapping software and timer bits.

These cases separate the three terms of the gating. The access path is tried in four combinations of privilege and usable bit, telling refused accesses apart from accepted ones.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int XLEN      = 32;
  localparam int IRQ_LINES = 8;
  localparam int IRQ_LSB   = 8;
  localparam int CU_LSB    = 28;
  localparam int CU_W      = 4;
  localparam int CE_LSB    = 28;
  localparam int CE_W      = 2;
  localparam int IE_BIT    = 0;

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_STATUS  = 2'd2,
    SEL_CAUSE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpt_rst_sync.sv
module cpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cpt_counter.sv
module cpt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         count_we,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count_o,
  output logic [W-1:0] compare_o,
  output logic         hit_o
);
  logic [W-1:0] count_q, count_d, count_inc;
  logic [W-1:0] cmp_q, cmp_d;
  logic         count_en, cmp_en;

  always_comb begin
    count_inc = count_q + W'(1);
    count_en  = count_we | tick;
    count_d   = count_we ? wdata : count_inc;
    cmp_en    = cmp_we;
    cmp_d     = wdata;
    // match is judged on the incremented value; a software load suppresses it
    hit_o     = tick & ~count_we & (count_inc == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      if (count_en) count_q <= count_d;
      if (cmp_en)   cmp_q   <= cmp_d;
    end
  end

  assign count_o   = count_q;
  assign compare_o = cmp_q;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !count_we) |=> (count_q == $past(count_q) + W'(1)));
  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    count_we |=> (count_q == $past(wdata)));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !count_we) |=> $stable(count_q));
endmodule

// File: rtl/cpt_cause.sv
module cpt_cause #(
  parameter int XLEN    = 32,
  parameter int LINES   = 8,
  parameter int IRQ_LSB = 8,
  parameter int CE_LSB  = 28,
  parameter int CE_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            timer_hit,
  input  logic            timer_clr,
  input  logic            sw_we,
  input  logic            fault,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] cause_o,
  output logic [LINES-1:0] ip_o
);
  localparam int TIMER = LINES - 1;

  logic [LINES-1:0] ip_q, ip_d;
  logic [CE_W-1:0]  ce_q, ce_d;
  logic             ip_en, ce_en;

  always_comb begin
    ip_d = ip_q;
    if (sw_we)     ip_d[TIMER-1:0] = wdata[IRQ_LSB +: TIMER];
    if (timer_hit) ip_d[TIMER] = 1'b1;
    if (timer_clr) ip_d[TIMER] = 1'b0;
    ip_en = sw_we | timer_hit | timer_clr;
    ce_d  = fault ? '0 : wdata[CE_LSB +: CE_W];
    ce_en = fault | sw_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= '0;
      ce_q <= '0;
    end else begin
      if (ip_en) ip_q <= ip_d;
      if (ce_en) ce_q <= ce_d;
    end
  end

  always_comb begin
    cause_o = '0;
    cause_o[IRQ_LSB +: LINES] = ip_q;
    cause_o[CE_LSB +: CE_W]   = ce_q;
  end
  assign ip_o = ip_q;

  a_r3_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_hit && !timer_clr) |=> ip_q[TIMER]);
  a_r4_timer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_q[TIMER] && !timer_clr) |=> ip_q[TIMER]);
  a_r5_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |=> !ip_q[TIMER]);
  a_r9_ce_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (ce_q == '0));
endmodule

// File: rtl/cpt_status.sv
module cpt_status #(
  parameter int XLEN    = 32,
  parameter int LINES   = 8,
  parameter int IRQ_LSB = 8,
  parameter int CU_LSB  = 28,
  parameter int CU_W    = 4,
  parameter int IE_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [XLEN-1:0]  wdata,
  input  logic [LINES-1:0] ip_i,
  output logic [XLEN-1:0]  status_o,
  output logic             irq_o
);
  logic [CU_W-1:0]  cu_q, cu_d;
  logic [LINES-1:0] im_q, im_d;
  logic             ie_q, ie_d;

  always_comb begin
    cu_d = wdata[CU_LSB +: CU_W];
    im_d = wdata[IRQ_LSB +: LINES];
    ie_d = wdata[IE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cu_q <= '0;
      im_q <= '0;
      ie_q <= 1'b0;
    end else if (we) begin
      cu_q <= cu_d;
      im_q <= im_d;
      ie_q <= ie_d;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[CU_LSB +: CU_W]   = cu_q;
    status_o[IRQ_LSB +: LINES] = im_q;
    status_o[IE_BIT]           = ie_q;
    irq_o = ie_q & (|(ip_i & im_q));
  end
endmodule

// File: rtl/cpt_timer_irq.sv
module cpt_timer_irq
  import cpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            kernel_mode,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] rd_data,
  output logic            cop_unusable,
  output logic            irq_req
);
  logic rst_n_i;
  logic fault, wr_ok, rd_ok;
  logic count_we, cmp_we, status_we, cause_we;
  logic timer_hit;
  logic [XLEN-1:0] count_v, compare_v, status_v, cause_v;
  logic [IRQ_LINES-1:0] ip_v;
  reg_sel_e sel;

  cpt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  always_comb begin
    sel       = reg_sel_e'(reg_sel);
    fault     = (reg_wr | reg_rd) & ~kernel_mode & ~status_v[CU_LSB];
    wr_ok     = reg_wr & ~fault;
    rd_ok     = reg_rd & ~fault;
    count_we  = wr_ok & (sel == SEL_COUNT);
    cmp_we    = wr_ok & (sel == SEL_COMPARE);
    status_we = wr_ok & (sel == SEL_STATUS);
    cause_we  = wr_ok & (sel == SEL_CAUSE);
    rd_data   = '0;
    if (rd_ok) begin
      unique case (sel)
        SEL_COUNT:   rd_data = count_v;
        SEL_COMPARE: rd_data = compare_v;
        SEL_STATUS:  rd_data = status_v;
        SEL_CAUSE:   rd_data = cause_v;
        default:     rd_data = '0;
      endcase
    end
  end
  assign cop_unusable = fault;

  cpt_counter #(.W(XLEN)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .tick(tick), .count_we(count_we),
    .cmp_we(cmp_we), .wdata(wr_data), .count_o(count_v),
    .compare_o(compare_v), .hit_o(timer_hit)
  );

  cpt_cause #(.XLEN(XLEN), .LINES(IRQ_LINES), .IRQ_LSB(IRQ_LSB),
              .CE_LSB(CE_LSB), .CE_W(CE_W)) u_cause (
    .clk(clk), .rst_n(rst_n_i), .timer_hit(timer_hit), .timer_clr(cmp_we),
    .sw_we(cause_we), .fault(fault), .wdata(wr_data),
    .cause_o(cause_v), .ip_o(ip_v)
  );

  cpt_status #(.XLEN(XLEN), .LINES(IRQ_LINES), .IRQ_LSB(IRQ_LSB),
               .CU_LSB(CU_LSB), .CU_W(CU_W), .IE_BIT(IE_BIT)) u_status (
    .clk(clk), .rst_n(rst_n_i), .we(status_we), .wdata(wr_data),
    .ip_i(ip_v), .status_o(status_v), .irq_o(irq_req)
  );

  a_r7_quiet_without_pending: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cause_v[IRQ_LSB +: IRQ_LINES] == '0) |-> !irq_req);
  a_r8_refused_cmp_kept: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fault && reg_wr && sel == SEL_COMPARE) |=> $stable(compare_v));
  a_r8_refused_read_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    cop_unusable |-> (rd_data == '0));
endmodule

// File: tb/test_cpt_timer_irq.sv
`timescale 1ns/1ps
module test_cpt_timer_irq;
  logic        clk = 1'b0;
  logic        rst_n, tick, kernel_mode, reg_wr, reg_rd;
  logic [1:0]  reg_sel;
  logic [31:0] wr_data, rd_data;
  logic        cop_unusable, irq_req;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cpt_timer_irq i_cpt_timer_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kernel_mode(kernel_mode),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data),
    .rd_data(rd_data), .cop_unusable(cop_unusable), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel; reg_rd = 1'b1;
    #1 d = rd_data;
    reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", {31'h0, irq_req}, 32'h0);
  endtask

  task automatic t_increment;
    logic [31:0] v;
    wr(2'd0, 32'd5);
    ticks(3);
    rd(2'd0, v); check("R2 count +3", v, 32'd8);
    rd(2'd3, v); check("R10 read zero when idle", rd_data, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    ticks(1);
    rd(2'd0, v); check("R2 wrap", v, 32'h0);
  endtask

  task automatic t_match;
    logic [31:0] v;
    wr(2'd1, 32'd100);
    wr(2'd0, 32'd98);
    ticks(1);
    rd(2'd3, v); check("R3 no set before match", v, 32'h0);
    ticks(1);
    rd(2'd0, v); check("R3 count at compare", v, 32'd100);
    rd(2'd3, v); check("R3 pending set", v, 32'h0000_8000);
    ticks(5);
    rd(2'd3, v); check("R4 sticky over ticks", v, 32'h0000_8000);
    wr(2'd3, 32'h0);
    rd(2'd3, v); check("R4 cause write keeps bit 15", v, 32'h0000_8000);
    wr(2'd1, 32'd200);
    rd(2'd3, v); check("R5 compare write clears", v, 32'h0);
    wr(2'd0, 32'd200);
    ticks(1);
    rd(2'd3, v); check("R3 old count equal does not set", v, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    ticks(1);
    rd(2'd3, v); check("R3 match on wrap", v, 32'h0000_8000);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(2'd1, 32'd50);
    @(negedge clk);
    reg_sel = 2'd0; wr_data = 32'd50; reg_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
    rd(2'd0, v); check("R6 load wins over tick", v, 32'd50);
    rd(2'd3, v); check("R6 no match on load", v, 32'h0);
  endtask

  task automatic t_irq;
    wr(2'd2, 32'h0000_0101);
    #1 check("R7 no pending no irq", {31'h0, irq_req}, 32'h0);
    wr(2'd3, 32'h0000_0100);
    #1 check("R7 sw pending masked in", {31'h0, irq_req}, 32'h1);
    wr(2'd2, 32'h0000_0100);
    #1 check("R7 enable off", {31'h0, irq_req}, 32'h0);
    wr(2'd2, 32'h0000_8001);
    #1 check("R7 mask mismatch", {31'h0, irq_req}, 32'h0);
    wr(2'd1, 32'd10);
    wr(2'd0, 32'd9);
    ticks(1);
    #1 check("R7 timer raises irq", {31'h0, irq_req}, 32'h1);
    wr(2'd1, 32'd10);
    #1 check("R5 irq drops after compare write", {31'h0, irq_req}, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R10 status fields", v, 32'hF000_FF01);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R10 cause fields", v, 32'h3000_7F00);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_access;
    logic [31:0] v;
    wr(2'd1, 32'd33);
    wr(2'd3, 32'h3000_0000);
    kernel_mode = 1'b0;
    @(negedge clk);
    reg_sel = 2'd1; wr_data = 32'd7; reg_wr = 1'b1;
    #1 check("R8 refused write flags", {31'h0, cop_unusable}, 32'h1);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_sel = 2'd1; reg_rd = 1'b1;
    #1 check("R8 refused read zero", rd_data, 32'h0);
    check("R8 refused read flags", {31'h0, cop_unusable}, 32'h1);
    reg_rd = 1'b0;
    kernel_mode = 1'b1;
    rd(2'd1, v); check("R8 compare unchanged", v, 32'd33);
    rd(2'd3, v); check("R9 error field zeroed", v, 32'h0);
    wr(2'd2, 32'h1000_0000);
    kernel_mode = 1'b0;
    @(negedge clk);
    reg_sel = 2'd1; wr_data = 32'd7; reg_wr = 1'b1;
    #1 check("R11 usable bit allows", {31'h0, cop_unusable}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd1, v); check("R11 user write taken", v, 32'd7);
    kernel_mode = 1'b1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; kernel_mode = 1'b1;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 2'd0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_increment();
    t_match();
    t_priority();
    t_irq();
    t_fields();
    t_access();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule